// File: doc/BRIEF.md
# FPU Error Interrupt Handshake Controller

This block turns a floating-point error-summary flag into a legacy interrupt request on the IRQ13 line. The interrupt is raised only while the numeric-error mode bit is 0. When that bit is 1, the native reporting path owns FPU errors and the interrupt line stays quiet. Software acknowledges the interrupt by writing one byte to either of two acknowledge ports, 0xF0 or 0xF1. The block watches processor I/O write cycles for that write. After the acknowledge, an "ignore numeric errors" signal goes to the FPU. That signal holds until the error summary drops, and then the block arms itself again.

The control is a three-state Moore machine:

- **MONITOR** is the reset state. The block waits for the error summary.
- **ASSERTED**: IRQ13 is driven and the block waits for the acknowledge.
- **IGNORE**: the FPU is told to ignore numeric errors until the summary clears.

The named transitions are:

- **RAISE**: MONITOR to ASSERTED, when the summary is high.
- **ACK**: ASSERTED to IGNORE, on a valid acknowledge write.
- **REARM**: IGNORE to MONITOR, when the summary is low.
- **MASK**: any state to MONITOR, whenever the mode bit is 1. MASK has priority over every other transition.

All other conditions hold the current state.

Top module: `fpu_err_irq_ctrl`

## Requirements
- R1: During reset and on the first cycle after it, `irq13` and `fpu_ignore_err` are 0 and the block is in MONITOR.
- R2: While `ne_mode` is 1, `irq13` is 0 in every cycle, whatever the state.
- R3: In MONITOR with `ne_mode` 0 and `err_summary` 1 at a clock edge (RAISE), `irq13` reads 1 after that edge.
- R4: In ASSERTED with `ne_mode` 0, `irq13` stays 1 until an acknowledge arrives, even if `err_summary` falls meanwhile.
- R5: An acknowledge is a cycle with `io_wr_valid` 1, `io_wr_size` equal to 2'b00 (one byte), and `io_wr_addr` equal to 16'h00F0 or 16'h00F1. In ASSERTED with `ne_mode` 0, an acknowledge (ACK) makes `irq13` 0 and `fpu_ignore_err` 1 after that edge.
- R6: Some writes leave the state unchanged: writes to any other address; writes of size 2'b01 (16-bit) or 2'b10 (32-bit), even to 0xF0 or 0xF1; and acknowledges received in MONITOR or IGNORE.
- R7: In IGNORE with `err_summary` still 1, `irq13` stays 0 and `fpu_ignore_err` stays 1.
- R8: In IGNORE with `ne_mode` 0 and `err_summary` 0 at an edge (REARM), `fpu_ignore_err` reads 0 after that edge. A later high summary raises `irq13` again.
- R9: `ne_mode` at 1 on an edge (MASK) returns the block to MONITOR from any state, so `fpu_ignore_err` and `irq13` read 0 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ne_mode | input | 1 | Numeric-error mode bit; 1 masks the legacy interrupt |
| err_summary | input | 1 | FPU error-summary status bit |
| io_wr_valid | input | 1 | An I/O write cycle is present this clock |
| io_wr_addr | input | 16 | I/O port address of the write |
| io_wr_size | input | 2 | Operand size: 00 byte, 01 16-bit, 10 32-bit |
| irq13 | output | 1 | Legacy FPU error interrupt request |
| fpu_ignore_err | output | 1 | Tells the FPU to ignore numeric errors |

## Verification
A wrong state shows on the two outputs on the first edge after the faulty transition. The outputs decode the state directly, so there is no pipeline to hide it. A lost RAISE leaves `irq13` low, and a missed REARM leaves `fpu_ignore_err` stuck at 1. A decoder that treats a near-miss write as an acknowledge drops `irq13` one cycle early. The bench starts from each of the three states and applies every combination of mode, summary and write kind. It compares both outputs one edge later. It then runs a long pseudo-random sequence, so that faults reached only through chained transitions are also seen.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

    typedef enum logic [1:0] {
        ST_MONITOR  = 2'd0,
        ST_ASSERTED = 2'd1,
        ST_IGNORE   = 2'd2
    } fpe_state_e;

    localparam int unsigned SIZE_W    = 2;
    localparam logic [SIZE_W-1:0] SIZE_BYTE = 2'b00;

endpackage

// File: rtl/fpe_ack_decode.sv
module fpe_ack_decode #(
    parameter int unsigned          ADDR_W    = 16,
    parameter int unsigned          ACK_PORTS = 2,
    parameter logic [ADDR_W-1:0]    ACK_BASE  = 16'h00F0
) (
    input  logic                        wr_valid,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [fpe_pkg::SIZE_W-1:0]  wr_size,
    output logic                        ack
);
    import fpe_pkg::*;

    logic [ACK_PORTS-1:0] port_hit;

    // One comparator per acknowledge port
    for (genvar g = 0; g < ACK_PORTS; g++) begin : g_port
        localparam logic [ADDR_W-1:0] PORT_ADDR = ACK_BASE + ADDR_W'(g);
        assign port_hit[g] = (wr_addr == PORT_ADDR);
    end

    assign ack = wr_valid && (wr_size == SIZE_BYTE) && (|port_hit);

endmodule

// File: rtl/fpe_state_ctrl.sv
module fpe_state_ctrl (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ne_mode,
    input  logic                err_summary,
    input  logic                ack,
    output fpe_pkg::fpe_state_e state
);
    import fpe_pkg::*;

    fpe_state_e state_q;
    fpe_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (ne_mode) begin
            state_d = ST_MONITOR;                      // MASK
        end else begin
            unique case (state_q)
                ST_MONITOR:  if (err_summary) state_d = ST_ASSERTED;  // RAISE
                ST_ASSERTED: if (ack)         state_d = ST_IGNORE;    // ACK
                ST_IGNORE:   if (!err_summary) state_d = ST_MONITOR;  // REARM
                default:     state_d = ST_MONITOR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_MONITOR;
        else        state_q <= state_d;
    end

    assign state = state_q;

    a_r3_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MONITOR && !ne_mode && err_summary) |=> (state_q == ST_ASSERTED));

    a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASSERTED && !ne_mode && !ack) |=> (state_q == ST_ASSERTED));

    a_r5_ack_to_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASSERTED && !ne_mode && ack) |=> (state_q == ST_IGNORE));

    a_r7_ignore_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE && !ne_mode && err_summary) |=> (state_q == ST_IGNORE));

    a_r8_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE && !ne_mode && !err_summary) |=> (state_q == ST_MONITOR));

    a_r9_mask: assert property (@(posedge clk) disable iff (!rst_n)
        ne_mode |=> (state_q == ST_MONITOR));

endmodule

// File: rtl/fpu_err_irq_ctrl.sv
module fpu_err_irq_ctrl #(
    parameter int unsigned          ADDR_W    = 16,
    parameter int unsigned          ACK_PORTS = 2,
    parameter logic [ADDR_W-1:0]    ACK_BASE  = 16'h00F0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ne_mode,
    input  logic                        err_summary,
    input  logic                        io_wr_valid,
    input  logic [ADDR_W-1:0]           io_wr_addr,
    input  logic [fpe_pkg::SIZE_W-1:0]  io_wr_size,
    output logic                        irq13,
    output logic                        fpu_ignore_err
);
    import fpe_pkg::*;

    logic       ack;
    fpe_state_e state;

    fpe_ack_decode #(
        .ADDR_W    (ADDR_W),
        .ACK_PORTS (ACK_PORTS),
        .ACK_BASE  (ACK_BASE)
    ) u_ack_decode (
        .wr_valid (io_wr_valid),
        .wr_addr  (io_wr_addr),
        .wr_size  (io_wr_size),
        .ack      (ack)
    );

    fpe_state_ctrl u_state_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ne_mode     (ne_mode),
        .err_summary (err_summary),
        .ack         (ack),
        .state       (state)
    );

    // Output process: decoded from state, IRQ masked by mode bit
    always_comb begin
        irq13          = 1'b0;
        fpu_ignore_err = 1'b0;
        unique case (state)
            ST_MONITOR:  ;
            ST_ASSERTED: irq13 = !ne_mode;
            ST_IGNORE:   fpu_ignore_err = 1'b1;
            default:     ;
        endcase
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!irq13 && !fpu_ignore_err));

    a_r2_mask_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ne_mode |-> !irq13);

    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq13 && fpu_ignore_err));

    a_r8_rearm_port: assert property (@(posedge clk) disable iff (!rst_n)
        (fpu_ignore_err && !err_summary) |=> !fpu_ignore_err);

endmodule

// File: tb/test_fpu_err_irq_ctrl.sv
module test_fpu_err_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ne_mode = 1'b0;
    logic        err_summary = 1'b0;
    logic        io_wr_valid = 1'b0;
    logic [15:0] io_wr_addr = 16'h0000;
    logic [1:0]  io_wr_size = 2'b00;
    logic        irq13;
    logic        fpu_ignore_err;

    int checks = 0;
    int fails  = 0;
    int model  = 0;   // 0 MONITOR, 1 ASSERTED, 2 IGNORE
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    fpu_err_irq_ctrl i_fpu_err_irq_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .ne_mode        (ne_mode),
        .err_summary    (err_summary),
        .io_wr_valid    (io_wr_valid),
        .io_wr_addr     (io_wr_addr),
        .io_wr_size     (io_wr_size),
        .irq13          (irq13),
        .fpu_ignore_err (fpu_ignore_err)
    );

    task automatic check(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    function automatic bit is_ack(bit v, logic [15:0] a, logic [1:0] s);
        return v && s == 2'b00 && (a == 16'h00F0 || a == 16'h00F1);
    endfunction

    function automatic int next_model(int s, bit ne, bit es, bit ack);
        if (ne) return 0;
        case (s)
            0: return es ? 1 : 0;
            1: return ack ? 2 : 1;
            default: return es ? 2 : 0;
        endcase
    endfunction

    // Apply inputs for one edge, then compare outputs just after it
    task automatic step(bit ne, bit es, bit v, logic [15:0] a, logic [1:0] s);
        string tag;
        bit ack;
        ack = is_ack(v, a, s);
        if (ne)                    tag = "R9";
        else if (model == 0)       tag = (v && !es) ? "R6" : "R3";
        else if (model == 1)       tag = ack ? "R5" : (v ? "R6" : "R4");
        else                       tag = es ? "R7" : "R8";
        ne_mode = ne; err_summary = es; io_wr_valid = v;
        io_wr_addr = a; io_wr_size = s;
        @(posedge clk);
        #2;
        model = next_model(model, ne, es, ack);
        check(tag, irq13, (model == 1) && !ne, "irq13");
        check(tag, fpu_ignore_err, model == 2, "fpu_ignore_err");
        if (ne) check("R2", irq13, 1'b0, "irq13 masked");
        io_wr_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ne_mode = 1'b0; err_summary = 1'b0; io_wr_valid = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        check("R1", irq13, 1'b0, "irq13 in reset");
        check("R1", fpu_ignore_err, 1'b0, "ignore in reset");
        rst_n = 1'b1;
        model = 0;
        @(posedge clk);
        #2;
        check("R1", irq13, 1'b0, "irq13 after reset");
        check("R1", fpu_ignore_err, 1'b0, "ignore after reset");
    endtask

    task automatic goto_state(int target);
        do_reset();
        if (target >= 1) step(0, 1, 0, 16'h0000, 2'b00);
        if (target >= 2) step(0, 1, 1, 16'h00F0, 2'b00);
    endtask

    function automatic logic [15:0] kind_addr(int k);
        case (k)
            1: return 16'h00F0;
            2: return 16'h00F1;
            3: return 16'h00F0;
            4: return 16'h00F1;
            5: return 16'h00F2;
            6: return 16'h00EF;
            default: return 16'h01F0;
        endcase
    endfunction

    function automatic logic [1:0] kind_size(int k);
        case (k)
            3: return 2'b01;
            4: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] lfsr;
        // Sweep: every start state x mode x summary x write kind
        for (int st = 0; st < 3; st++) begin
            for (int ne = 0; ne < 2; ne++) begin
                for (int es = 0; es < 2; es++) begin
                    for (int k = 0; k < 8; k++) begin
                        goto_state(st);
                        step(ne[0], es[0], k != 0, kind_addr(k), kind_size(k));
                        // one follow-up edge with quiet inputs
                        step(0, es[0], 0, 16'h0000, 2'b00);
                    end
                end
            end
        end

        // Full cycle, including summary falling while asserted (R4) and rearm (R8)
        goto_state(0);
        step(0, 1, 0, 16'h0000, 2'b00);
        step(0, 0, 0, 16'h0000, 2'b00);
        step(0, 0, 1, 16'h00F1, 2'b10);
        step(0, 0, 1, 16'h00F1, 2'b00);
        step(0, 0, 0, 16'h0000, 2'b00);
        step(0, 1, 0, 16'h0000, 2'b00);

        // Pseudo-random sequence checked against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            bit ne_r, es_r, v_r;
            logic [15:0] a_r;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ne_r = (lfsr[3:0] == 4'h0);
            es_r = lfsr[5] | lfsr[6];
            v_r  = lfsr[7];
            a_r  = lfsr[8] ? 16'h00F0 : (lfsr[9] ? 16'h00F1 : 16'h00F3);
            step(ne_r, es_r, v_r, a_r, {1'b0, lfsr[10] & lfsr[11]});
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule